// File: doc/BRIEF.md
# Pointer-Addressed SMBus Register Target

This block is a two-wire serial bus target (SMBus / I2C compatible) that exposes a bank of 16-bit registers. An 8-bit pointer register selects the register. A write transaction always carries the pointer byte after the address byte. The data that follows, if any, is two bytes with the high byte first, and it lands in the register that the pointer selects. The pointer keeps its value across transactions. This allows a read to skip the pointer phase, or to set the pointer first and then switch direction with a repeated START.

The register contents live outside the block, behind a plain register-file port: an address (the pointer), write data, a one-cycle write strobe, and combinational read data. Each register slot is read/write, read-only or write-only, chosen by two parameter masks. Pointer values past the register count are reserved. The block also keeps an alert flag that is raised by a request pulse and driven out active-low. While the flag is raised, the block answers a read to the alert response address with its own device address. It then drops the flag.

The bus lines are brought onto a system clock through a two-flop synchronizer and edge-detected there. The system clock must run at least eight times faster than SCL. SDA is driven open-drain through an output-enable.

Top module: `ptr_reg_smbus_slave`

## Requirements
- R1: After reset the pointer (rf_addr) is 0x00, sda_oe is 0, rf_we is 0 and alert_n is 1.
- R2: The pointer keeps the last value written to it. A read that carries no pointer byte (address with R/W=1, then two data bytes) returns the register the held pointer selects.
- R3: A write transaction that ends with STOP right after the pointer byte changes only the pointer. No rf_we strobe is issued.
- R4: A write of two data bytes produces exactly one rf_we pulse, with rf_wdata = {first byte, second byte} and rf_addr = pointer. A data byte beyond the second is not acknowledged.
- R5: A read of the form address(W), pointer, repeated START, address(R) returns the register selected by the new pointer, high byte first.
- R6: Bytes are shifted MSB first and sampled on SCL rising edges. The target pulls SDA low during the ninth clock to acknowledge. sda_oe changes only while SCL is low.
- R7: After the last read byte, the target accepts either ACK or NACK from the master. It then leaves SDA released until the next START or STOP.
- R8: A write to a read-only slot (RO_MASK bit set) or to a pointer at or above NUM_REGS issues no strobe. A read of a write-only slot (WO_MASK bit set) or of a reserved pointer returns 0x0000.
- R9: A one-cycle alert_set pulse drives alert_n low. While alert_n is low, a read to address 7'b0001100 is acknowledged and returns {dev_addr, 1'b0}. Once that byte has been transferred, alert_n returns to 1.
- R10: An address byte whose 7-bit address matches neither dev_addr nor an active alert response read is not acknowledged. The target stays idle until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| dev_addr | input | 7 | Strapped 7-bit device address |
| rf_addr | output | 8 | Current pointer value, register-file address |
| rf_wdata | output | 16 | Write data, first received byte in bits 15:8 |
| rf_we | output | 1 | One-cycle write strobe |
| rf_rdata | input | 16 | Register-file read data for rf_addr |
| alert_set | input | 1 | Pulse that raises the alert flag |
| alert_n | output | 1 | Active-low alert output |

## Verification
The bench drives the bus as a master and tries both read forms: a plain read that relies on the held pointer, and a pointer write followed by a repeated START. The two forms separate a pointer that persists from one that has to be resent. Writes go to a read/write slot, a read-only slot, a write-only slot and a reserved pointer, and a pointer-only write is also sent. Each write strobe is compared against the bench's own expected-write queue on every clock. This tells strobe suppression apart from data routing. Alert-response reads with the flag raised and with it lowered, a foreign address, a master ACK on the final read byte and a third data byte check the acknowledge decisions.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam logic [6:0] ALERT_RESP_ADDR = 7'b0001100;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK_OUT, ST_TX, ST_ACK_IN, ST_WAIT
    } link_st_t;

    typedef enum logic [2:0] {
        PH_ADDR, PH_PTR, PH_DHI, PH_DLO, PH_RDHI, PH_RDLO, PH_ARA
    } phase_t;

    typedef enum logic [1:0] {ACC_RW, ACC_RO, ACC_WO, ACC_NONE} access_t;

    function automatic access_t acc_decode(input logic ro, input logic wo);
        if (ro && wo) return ACC_NONE;
        if (ro)       return ACC_RO;
        if (wo)       return ACC_WO;
        return ACC_RW;
    endfunction

endpackage

// File: rtl/psr_line_sync.sv
module psr_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_pipe, sda_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[DEPTH-2:0], scl_in};
            sda_pipe <= {sda_pipe[DEPTH-2:0], sda_in};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_pipe[DEPTH-2];
    assign scl_old = scl_pipe[DEPTH-1];
    assign sda_now = sda_pipe[DEPTH-2];
    assign sda_old = sda_pipe[DEPTH-1];

    assign sda_s     = sda_now;
    assign scl_rise  = scl_now & ~scl_old;
    assign scl_fall  = ~scl_now & scl_old;
    assign start_det = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/psr_link.sv
module psr_link
    import psr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter logic [NUM_REGS-1:0] RO_MASK = '0,
    parameter logic [NUM_REGS-1:0] WO_MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [6:0]        dev_addr,
    input  logic              alert_active,
    input  logic [WORD_W-1:0] rf_rdata,
    output logic [BYTE_W-1:0] ptr,
    output logic [WORD_W-1:0] wdata,
    output logic              we,
    output logic              sda_oe,
    output logic              ara_done
);
    link_st_t          st, fol_st;
    phase_t            ph;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh, rd_lo, hi_q;
    logic              m_ack;

    // access class of the slot the pointer selects
    access_t acc;
    always_comb begin
        acc = ACC_NONE;
        for (int i = 0; i < NUM_REGS; i++)
            if (ptr == BYTE_W'(i)) acc = acc_decode(RO_MASK[i], WO_MASK[i]);
    end

    logic              can_rd, can_wr;
    logic [WORD_W-1:0] rd_val;
    assign can_rd = (acc == ACC_RW) || (acc == ACC_RO);
    assign can_wr = (acc == ACC_RW) || (acc == ACC_WO);
    assign rd_val = can_rd ? rf_rdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;  fol_st <= ST_IDLE;  ph <= PH_ADDR;
            cnt <= '0;  rx_sh <= '0;  tx_sh <= '0;  rd_lo <= '0;  hi_q <= '0;
            ptr <= '0;  wdata <= '0;  we <= 1'b0;  sda_oe <= 1'b0;
            m_ack <= 1'b0;  ara_done <= 1'b0;
        end else begin
            we       <= 1'b0;
            ara_done <= 1'b0;
            if (start_det) begin
                st <= ST_RX;  ph <= PH_ADDR;  cnt <= '0;  sda_oe <= 1'b0;
            end else if (stop_det) begin
                st <= ST_IDLE;  sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            sda_oe <= 1'b1;
                            st     <= ST_ACK_OUT;
                            fol_st <= ST_RX;
                            case (ph)
                                PH_ADDR: begin
                                    if (rx_sh[7:1] == dev_addr) begin
                                        if (rx_sh[0]) begin
                                            fol_st <= ST_TX;
                                            ph     <= PH_RDHI;
                                            tx_sh  <= rd_val[WORD_W-1:BYTE_W];
                                            rd_lo  <= rd_val[BYTE_W-1:0];
                                        end else begin
                                            ph <= PH_PTR;
                                        end
                                    end else if (rx_sh[7:1] == ALERT_RESP_ADDR
                                                 && rx_sh[0] && alert_active) begin
                                        fol_st <= ST_TX;
                                        ph     <= PH_ARA;
                                        tx_sh  <= {dev_addr, 1'b0};
                                    end else begin
                                        sda_oe <= 1'b0;
                                        st     <= ST_IDLE;
                                    end
                                end
                                PH_PTR: begin
                                    ptr <= rx_sh;
                                    ph  <= PH_DHI;
                                end
                                PH_DHI: begin
                                    hi_q <= rx_sh;
                                    ph   <= PH_DLO;
                                end
                                default: begin
                                    wdata  <= {hi_q, rx_sh};
                                    we     <= can_wr;
                                    fol_st <= ST_WAIT;
                                end
                            endcase
                        end
                    end
                    ST_ACK_OUT: begin
                        if (scl_fall) begin
                            st     <= fol_st;
                            cnt    <= '0;
                            sda_oe <= (fol_st == ST_TX) ? ~tx_sh[BYTE_W-1] : 1'b0;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                st     <= ST_ACK_IN;
                                sda_oe <= 1'b0;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_ACK_IN: begin
                        if (scl_rise) begin
                            m_ack    <= ~sda_s;
                            ara_done <= (ph == PH_ARA);
                        end else if (scl_fall) begin
                            if (ph == PH_RDHI && m_ack) begin
                                st     <= ST_TX;
                                ph     <= PH_RDLO;
                                cnt    <= '0;
                                tx_sh  <= rd_lo;
                                sda_oe <= ~rd_lo[BYTE_W-1];
                            end else begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/psr_alert.sv
module psr_alert (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic active
);
    always_ff @(posedge clk) begin
        if (rst)           active <= 1'b0;
        else if (set_req)  active <= 1'b1;
        else if (clr_req)  active <= 1'b0;
    end
endmodule

// File: rtl/ptr_reg_smbus_slave.sv
module ptr_reg_smbus_slave
    import psr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [NUM_REGS-1:0] RO_MASK = 8'b0000_0011,
    parameter logic [NUM_REGS-1:0] WO_MASK = 8'b0001_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_oe,
    input  logic [6:0]  dev_addr,
    output logic [7:0]  rf_addr,
    output logic [15:0] rf_wdata,
    output logic        rf_we,
    input  logic [15:0] rf_rdata,
    input  logic        alert_set,
    output logic        alert_n
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic alert_active, ara_done;

    psr_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    psr_link #(.NUM_REGS(NUM_REGS), .RO_MASK(RO_MASK), .WO_MASK(WO_MASK)) link_i (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .dev_addr(dev_addr), .alert_active(alert_active), .rf_rdata(rf_rdata),
        .ptr(rf_addr), .wdata(rf_wdata), .we(rf_we), .sda_oe(sda_oe),
        .ara_done(ara_done)
    );

    psr_alert alert_i (
        .clk(clk), .rst(rst), .set_req(alert_set), .clr_req(ara_done),
        .active(alert_active)
    );

    assign alert_n = ~alert_active;
endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
    parameter int NUM_REGS = 8,
    parameter logic [NUM_REGS-1:0] RO_MASK = '0
) (
    input logic       clk,
    input logic       rst,
    input logic       scl_in,
    input logic       sda_oe,
    input logic [7:0] rf_addr,
    input logic       rf_we,
    input logic       alert_set,
    input logic       alert_n
);
    logic slot_writable;
    always_comb begin
        slot_writable = 1'b0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rf_addr == 8'(i)) slot_writable = ~RO_MASK[i];
    end

    AST_PTR_RESET: assert property (@(posedge clk) rst |=> (rf_addr == 8'h00)); // R1

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we); // R4

    AST_WE_WRITABLE: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> slot_writable); // R8

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_in); // R6

    AST_ALERT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(alert_n) |-> $past(alert_set)); // R9
endmodule

bind ptr_reg_smbus_slave psr_checker #(.NUM_REGS(NUM_REGS), .RO_MASK(RO_MASK)) chk_i (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_oe(sda_oe), .rf_addr(rf_addr),
    .rf_we(rf_we), .alert_set(alert_set), .alert_n(alert_n)
);

// File: tb/ptr_reg_smbus_slave_tb.sv
module ptr_reg_smbus_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 20;
    localparam logic [6:0] DEV = 7'h18;
    localparam logic [6:0] ARA = 7'b0001100;
    localparam logic [7:0] RO_M = 8'b0000_0011;
    localparam logic [7:0] WO_M = 8'b0001_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic alert_set = 1'b0;
    logic sda_oe, rf_we, alert_n;
    logic [7:0]  rf_addr;
    logic [15:0] rf_wdata, rf_rdata;
    logic sda_line;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    ptr_reg_smbus_slave dut_i (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .dev_addr(DEV), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we),
        .rf_rdata(rf_rdata), .alert_set(alert_set), .alert_n(alert_n)
    );

    function automatic logic [15:0] init_val(int i);
        return 16'h1234 + 16'(i) * 16'h1111;
    endfunction

    // external register file
    logic [15:0] mem [8];
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) mem[i] <= init_val(i);
        end else if (rf_we && rf_addr < 8) begin
            mem[rf_addr[2:0]] <= rf_wdata;
        end
    end
    assign rf_rdata = (rf_addr < 8) ? mem[rf_addr[2:0]] : 16'hBEEF;

    // behavioural model
    logic [15:0] model [8];
    logic [23:0] exp_we_q [$];

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // strobe comparison every clock
    always @(negedge clk) begin
        if (!rst && rf_we) begin
            vectors++;
            if (exp_we_q.size() == 0) begin
                miscompares++;
                $display("FAIL R3/R8: actual strobe %h:%h expected none", rf_addr, rf_wdata);
            end else begin
                logic [23:0] e;
                e = exp_we_q.pop_front();
                if ({rf_addr, rf_wdata} !== e) begin
                    miscompares++;
                    $display("FAIL R4: actual %h expected %h", {rf_addr, rf_wdata}, e);
                end
            end
        end
    end

    task automatic wait_h(int n); repeat (n) @(posedge clk); endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_h(HALF/2); m_scl = 1'b1; wait_h(HALF);
        m_sda = 1'b0; wait_h(HALF); m_scl = 1'b0; wait_h(HALF/2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_h(HALF/2); m_scl = 1'b1; wait_h(HALF);
        m_sda = 1'b1; wait_h(HALF);
    endtask

    task automatic send_bit(logic b);
        m_sda = b; wait_h(HALF/2); m_scl = 1'b1; wait_h(HALF);
        m_scl = 1'b0; wait_h(HALF/2);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wait_h(HALF/2); m_scl = 1'b1; wait_h(HALF/2);
        @(negedge clk); b = sda_line; wait_h(HALF/2);
        m_scl = 1'b0; wait_h(HALF/2);
    endtask

    task automatic send_byte(logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        acked = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
        send_bit(~give_ack);
    endtask

    function automatic logic [15:0] exp_read(logic [7:0] p);
        if (p < 8 && !WO_M[p[2:0]]) return model[p[2:0]];
        return 16'h0000;
    endfunction

    task automatic wr_reg(logic [7:0] p, logic [15:0] d);
        logic a;
        if (p < 8 && !RO_M[p[2:0]]) begin
            exp_we_q.push_back({p, d});
            model[p[2:0]] = d;
        end
        bus_start();
        send_byte({DEV, 1'b0}, a); send_byte(p, a);
        send_byte(d[15:8], a); send_byte(d[7:0], a);
        check("R4 write ack", 16'(a), 16'h1);
        bus_stop();
    endtask

    task automatic rd_plain(output logic [15:0] v, input logic last_ack);
        logic a;
        bus_start();
        send_byte({DEV, 1'b1}, a);
        recv_byte(v[15:8], 1'b1); recv_byte(v[7:0], last_ack);
        bus_stop();
    endtask

    task automatic rd_rs(logic [7:0] p, output logic [15:0] v);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a); send_byte(p, a);
        bus_start();
        send_byte({DEV, 1'b1}, a);
        recv_byte(v[15:8], 1'b1); recv_byte(v[7:0], 1'b0);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0] b;
        logic a, bit_v;
        for (int i = 0; i < 8; i++) model[i] = init_val(i);
        wait_h(5);
        @(negedge clk);
        // R1: reset state
        check("R1 ptr", 16'(rf_addr), 16'h0);
        check("R1 sda_oe", 16'(sda_oe), 16'h0);
        check("R1 alert_n", 16'(alert_n), 16'h1);
        rst = 1'b0;
        wait_h(5);

        // R2: plain read uses reset pointer 0
        rd_plain(v, 1'b0);
        check("R2 plain read ptr0", v, exp_read(8'h00));

        // R3: pointer-only write, then plain read sees new pointer
        bus_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h03, a); bus_stop();
        check("R3 ptr ack", 16'(a), 16'h1);
        check("R3 ptr value", 16'(rf_addr), 16'h03);
        rd_plain(v, 1'b0);
        check("R2 held pointer read", v, exp_read(8'h03));

        // R4 + R5 + R6: write then repeated-start read
        wr_reg(8'h03, 16'hA5C3);
        rd_rs(8'h03, v);
        check("R5 rs read", v, 16'hA5C3);
        wr_reg(8'h02, 16'h8001);
        rd_rs(8'h02, v);
        check("R6 msb-first pattern", v, 16'h8001);

        // R8: read-only slot keeps value
        wr_reg(8'h01, 16'hFFFF);
        rd_rs(8'h01, v);
        check("R8 ro unchanged", v, exp_read(8'h01));
        // R8: write-only slot takes write, reads zero
        wr_reg(8'h04, 16'h5A5A);
        rd_rs(8'h04, v);
        check("R8 wo reads zero", v, 16'h0000);
        check("R8 wo stored", mem[4], 16'h5A5A);
        // R8: reserved pointer
        wr_reg(8'h20, 16'h7777);
        rd_rs(8'h20, v);
        check("R8 reserved reads zero", v, 16'h0000);

        // R4: third data byte not acknowledged
        exp_we_q.push_back({8'h05, 16'h1357});
        model[5] = 16'h1357;
        bus_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h05, a);
        send_byte(8'h13, a); send_byte(8'h57, a); send_byte(8'h99, a);
        check("R4 third byte nack", 16'(a), 16'h0);
        bus_stop();
        rd_plain(v, 1'b0);
        check("R4 two-byte value", v, 16'h1357);

        // R7: master ACKs last byte; slave releases SDA afterwards
        bus_start(); send_byte({DEV, 1'b1}, a);
        recv_byte(b, 1'b1); recv_byte(b, 1'b1);
        recv_bit(bit_v);
        check("R7 released after ack", 16'(bit_v), 16'h1);
        bus_stop();
        rd_plain(v, 1'b0);
        check("R7 next read ok", v, 16'h1357);

        // R10: foreign address
        bus_start(); send_byte({7'h19, 1'b0}, a);
        check("R10 foreign nack", 16'(a), 16'h0);
        send_byte(8'h00, a);
        check("R10 stays idle", 16'(a), 16'h0);
        bus_stop();
        check("R10 ptr kept", 16'(rf_addr), 16'h05);

        // R10: ARA while alert inactive
        bus_start(); send_byte({ARA, 1'b1}, a);
        check("R10 ara ignored", 16'(a), 16'h0);
        bus_stop();

        // R9: alert and alert response
        @(negedge clk); alert_set = 1'b1; @(negedge clk); alert_set = 1'b0;
        @(negedge clk);
        check("R9 alert low", 16'(alert_n), 16'h0);
        bus_start(); send_byte({ARA, 1'b1}, a);
        check("R9 ara ack", 16'(a), 16'h1);
        recv_byte(b, 1'b0);
        bus_stop();
        check("R9 ara byte", 16'(b), 16'({DEV, 1'b0}));
        check("R9 alert released", 16'(alert_n), 16'h1);

        wait_h(10);
        check("R3 no pending strobes", 16'(exp_we_q.size()), 16'h0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule